// File: doc/BRIEF.md
# PCM Frame Sync Receiver

This block turns a serial PCM stream into parallel words. It runs on an externally supplied bit shift clock and samples the serial data and the frame sync on every rising edge. The sync may be either polarity. An inversion bit flips it before any detection is done, so the rest of the logic always sees an active-high sync.

Two sync styles are supported. With a short sync, the sync is active for a single bit clock, and the most significant data bit follows on the next bit clock. With a long sync, the first data bit is on the line at the same time as the sync. It is captured on the first rising bit-clock edge that sees the sync active, and the sync must remain active on the next edge. Words are 8 or 16 bits wide and are shifted in most significant bit first.

When the final bit is in, the word is presented together with a one-clock valid strobe. The framing-error flag pulses under two conditions: a long sync that is too short, and a new sync that arrives before the current word is complete.

Top module: `pcm_sync_rx`

## Requirements
- R1: While `rstN` is low, and after it is released, `word` is 0 and `wordValid` and `frameErr` are 0.
- R2: In long-sync mode (`cfgLongSync`=1), the edge that first samples the sync active after an inactive sample captures the word's most significant bit. Later bits follow on each later edge, most significant first.
- R3: In short-sync mode (`cfgLongSync`=0), the edge that samples the sync active captures no data. The most significant bit is captured on the next edge, and the sync may return inactive on that edge.
- R4: With `cfgWide`=1 a word is 16 bits in `word[15:0]`. With `cfgWide`=0 a word is 8 bits in `word[7:0]`, and `word[15:8]` reads 0.
- R5: `wordValid` is high for exactly one clock, starting just after the edge that captures the last bit. `word` changes only together with `wordValid` and holds its value until the next word is delivered.
- R6: With `cfgInvSync`=1, a low level on `frameSync` is the active sync level and a high level is inactive. With `cfgInvSync`=0, high is active.
- R7: In long-sync mode, if the sync is inactive on the edge after the one that started the frame, `frameErr` pulses for one clock. The word is dropped and `wordValid` stays low.
- R8: A new sync activation seen while a word is still being captured pulses `frameErr`. The partial word is discarded, and the new activation starts a new frame under the R2 or R3 rule.
- R9: A new frame starts only after the sync has been sampled inactive on at least one edge. A sync held active across many edges delivers a single word.
- R10: In short-sync mode a single-clock sync never raises `frameErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit shift clock; all sampling on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| serData | input | 1 | Serial PCM data, most significant bit first |
| frameSync | input | 1 | Frame sync as driven on the line |
| cfgLongSync | input | 1 | 1 selects long sync, 0 selects short sync |
| cfgInvSync | input | 1 | 1 treats a low frame sync as active |
| cfgWide | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| word | output | 16 | Last received word, zero-extended for 8-bit words |
| wordValid | output | 1 | One-clock strobe when `word` is updated |
| frameErr | output | 1 | One-clock strobe on a sync timing violation or an aborted word |

## Verification
Clean frames are sent in every combination of sync style, word width and polarity. The data values include alternating, single-bit and all-ones patterns. These frames show whether the first bit lands on the sync edge or one edge later, whether the narrow word is zero-extended, and whether an inverted line level is decoded the same way as a normal one.

Directed sequences then cover the error paths and the sync-hold case. These are a one-clock long sync, a sync that restarts partway through a word, and a sync held active for two words' worth of clocks. They distinguish a dropped word from a mistimed one, and a restart from a late delivery.

// File: rtl/pcm_sync_rx_pkg.sv
package pcm_sync_rx_pkg;

  // Strobes from control to datapath, one bundle per bit clock
  typedef struct packed {
    logic start;   // load the first bit, count restarts at one
    logic shift;   // shift in one more bit
    logic commit;  // with shift: this is the last bit, publish the word
  } rxStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,  // short sync seen, data starts next edge
    ST_RUN  = 2'd2
  } rxState_t;

endpackage

// File: rtl/pcm_sync_rx_dp.sv
module pcm_sync_rx_dp
  import pcm_sync_rx_pkg::*;
#(
  parameter int MAX_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serData,
  input  logic             cfgWide,
  input  rxStrobe_t        strobe,
  output logic             lastBit,
  output logic [MAX_W-1:0] word,
  output logic             wordValid
);

  localparam int CNT_W = $clog2(MAX_W);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(MAX_W - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(NARROW_W - 1);

  logic [MAX_W-1:0] shiftReg;
  logic [MAX_W-1:0] shiftNext;
  logic [CNT_W-1:0] bitCnt;

  assign shiftNext = {shiftReg[MAX_W-2:0], serData};
  assign lastBit   = (bitCnt == (cfgWide ? LAST_WIDE : LAST_NARROW));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      bitCnt    <= '0;
      word      <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= strobe.commit;
      if (strobe.start) begin
        shiftReg <= {{(MAX_W-1){1'b0}}, serData};
        bitCnt   <= CNT_W'(1);
      end else if (strobe.shift) begin
        shiftReg <= shiftNext;
        bitCnt   <= strobe.commit ? '0 : bitCnt + CNT_W'(1);
        if (strobe.commit) word <= shiftNext;
      end
    end
  end

  // A narrow word never carries upper bits
  p_word_narrow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !cfgWide) |-> (word[MAX_W-1:NARROW_W] == '0));

  // The published word moves only together with the strobe
  p_word_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (word != $past(word)) |-> wordValid);

endmodule

// File: rtl/pcm_sync_rx_ctrl.sv
module pcm_sync_rx_ctrl
  import pcm_sync_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameSync,
  input  logic      cfgLongSync,
  input  logic      cfgInvSync,
  input  logic      lastBit,
  output rxStrobe_t strobe,
  output logic      frameErr
);

  rxState_t state, stateNext;
  logic syncIn, syncPrev, syncRise;
  logic chkHigh, chkHighNext;
  logic errNow;

  assign syncIn   = frameSync ^ cfgInvSync;
  assign syncRise = syncIn && !syncPrev;

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    errNow      = 1'b0;
    chkHighNext = 1'b0;
    if (syncRise) begin
      // a new frame wins over whatever was in progress
      errNow = (state != ST_IDLE);
      if (cfgLongSync) begin
        strobe.start = 1'b1;
        chkHighNext  = 1'b1;
        stateNext    = ST_RUN;
      end else begin
        stateNext = ST_ARM;
      end
    end else if (chkHigh && !syncIn) begin
      errNow    = 1'b1;
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_ARM: begin
          strobe.start = 1'b1;
          stateNext    = ST_RUN;
        end
        ST_RUN: begin
          strobe.shift  = 1'b1;
          strobe.commit = lastBit;
          if (lastBit) stateNext = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      syncPrev <= 1'b1;  // a sync already active at reset release is not an edge
      chkHigh  <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      state    <= stateNext;
      syncPrev <= syncIn;
      chkHigh  <= chkHighNext;
      frameErr <= errNow;
    end
  end

  // Long-sync capture only begins after an inactive sample
  p_start_after_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.start && cfgLongSync) |-> !$past(syncIn));

  // A long sync that drops on its second edge is reported
  p_min_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    (chkHigh && !syncIn) |=> frameErr);

endmodule

// File: rtl/pcm_sync_rx.sv
module pcm_sync_rx
  import pcm_sync_rx_pkg::*;
#(
  parameter int MAX_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serData,
  input  logic             frameSync,
  input  logic             cfgLongSync,
  input  logic             cfgInvSync,
  input  logic             cfgWide,
  output logic [MAX_W-1:0] word,
  output logic             wordValid,
  output logic             frameErr
);

  rxStrobe_t strobe;
  logic      lastBit;

  pcm_sync_rx_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameSync  (frameSync),
    .cfgLongSync(cfgLongSync),
    .cfgInvSync (cfgInvSync),
    .lastBit    (lastBit),
    .strobe     (strobe),
    .frameErr   (frameErr)
  );

  pcm_sync_rx_dp #(.MAX_W(MAX_W), .NARROW_W(NARROW_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .serData  (serData),
    .cfgWide  (cfgWide),
    .strobe   (strobe),
    .lastBit  (lastBit),
    .word     (word),
    .wordValid(wordValid)
  );

  // An errored edge never also delivers a word
  p_err_excl_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> !wordValid);

endmodule

// File: tb/pcm_sync_rx_bench.sv
module pcm_sync_rx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {long, wide, inv, data[15:0]}
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 16'h00A5},
    {1'b0, 1'b0, 1'b0, 16'h0081},
    {1'b1, 1'b1, 1'b0, 16'hC35A},
    {1'b0, 1'b1, 1'b0, 16'h8001},
    {1'b1, 1'b0, 1'b1, 16'h003C},
    {1'b0, 1'b1, 1'b1, 16'hFFFF},
    {1'b1, 1'b1, 1'b1, 16'h0001},
    {1'b0, 1'b0, 1'b1, 16'h00FE}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serData = 1'b0, frameSync = 1'b0;
  logic cfgLongSync = 1'b0, cfgInvSync = 1'b0, cfgWide = 1'b0;
  logic [15:0] word;
  logic wordValid, frameErr;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_sync_rx u_pcm_sync_rx (
    .clk(clk), .rstN(rstN), .serData(serData), .frameSync(frameSync),
    .cfgLongSync(cfgLongSync), .cfgInvSync(cfgInvSync), .cfgWide(cfgWide),
    .word(word), .wordValid(wordValid), .frameErr(frameErr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // logical sync level, converted to the line level by the current polarity
  task automatic step(input bit syncActive, input bit d);
    @(negedge clk);
    frameSync = syncActive ^ cfgInvSync;
    serData   = d;
    @(posedge clk);
    #1;
  endtask

  task automatic sendFrame(input logic [18:0] v, input string tag);
    int n;
    int wrong;
    logic [15:0] expWord;
    cfgLongSync = v[18];
    cfgWide     = v[17];
    cfgInvSync  = v[16];
    n = v[17] ? 16 : 8;
    expWord = v[17] ? v[15:0] : {8'h00, v[7:0]};
    wrong = 0;
    step(1'b0, 1'b0);
    if (!v[18]) begin
      step(1'b1, 1'b0);
      if (wordValid || frameErr) wrong++;
    end
    for (int i = 0; i < n; i++) begin
      step(v[18] && i < 2, v[n-1-i]);
      if (wordValid != (i == n-1)) wrong++;
      if (frameErr) wrong++;
    end
    chk(wrong == 0, {tag, " R2 R3 R5 R10 strobe timing"}, wrong, 0);
    chk(word == expWord, {tag, " R4 R6 word"}, word, expWord);
    step(1'b0, 1'b0);
    chk(!wordValid && word == expWord, {tag, " R5 valid drop, word held"},
        {wordValid, word}, {1'b0, expWord});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int valids;
    repeat (3) @(posedge clk);
    #1;
    chk(word == 0 && !wordValid && !frameErr, "R1 during reset",
        {wordValid, frameErr, word}, 0);
    @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 1'b0);
    chk(word == 0 && !wordValid && !frameErr, "R1 after release",
        {wordValid, frameErr, word}, 0);

    for (int k = 0; k < NVEC; k++) sendFrame(VEC[k], $sformatf("vec%0d", k));

    // R7: long sync active for one edge only
    cfgLongSync = 1'b1; cfgWide = 1'b0; cfgInvSync = 1'b0;
    step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    chk(!frameErr, "R7 no error on first edge", frameErr, 0);
    step(1'b0, 1'b0);
    chk(frameErr, "R7 short long-sync flagged", frameErr, 1);
    valids = 0;
    for (int i = 0; i < 10; i++) begin
      step(1'b0, 1'b1);
      if (wordValid) valids++;
    end
    chk(valids == 0 && word == 16'h00FE, "R7 word dropped", valids, 0);

    // R8: restart in the middle of a word, then a clean word 0x96
    step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    for (int i = 0; i < 8; i++) begin
      step(i < 2, 8'h96 >> (7 - i));
      if (i == 0) chk(frameErr && !wordValid, "R8 abort flagged", {frameErr, wordValid}, 2'b10);
    end
    chk(wordValid && word == 16'h0096, "R8 new frame captured", {wordValid, word}, {1'b1, 16'h0096});

    // R9: sync held active over two words of clocks gives one word 0x5B
    step(1'b0, 1'b0);
    valids = 0;
    for (int i = 0; i < 16; i++) begin
      step(1'b1, (i < 8) ? ((8'h5B >> (7 - i)) & 1) : 1'b1);
      if (wordValid) valids++;
    end
    chk(valids == 1 && word == 16'h005B, "R9 single word while held", valids, 1);

    // R10 and R6: inverted short sync, line low for one clock, 16-bit word
    cfgLongSync = 1'b0; cfgWide = 1'b1; cfgInvSync = 1'b1;
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    valids = 0;
    for (int i = 0; i < 16; i++) begin
      step(1'b0, (16'h1234 >> (15 - i)) & 1);
      if (frameErr) valids++;
    end
    chk(valids == 0, "R10 no error on single-clock short sync", valids, 0);
    chk(wordValid && word == 16'h1234, "R6 inverted short frame", word, 16'h1234);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule